// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one timer channel that produces a pulse-width-modulated waveform. A free-running up-counter is compared against two active compare values. The duty value sets the edge where the output returns to the polarity level. The period value sets the edge where the output goes to the opposite level and the counter restarts at one. Software writes only to staging copies of both values. The staging copies are moved into the active pair at the period boundary, so a waveform in progress is never disturbed by a write.

The output is held in a single flip-flop. A synchronous disable input, when it is enabled for the channel, drives that flip-flop to the polarity level on the next clock. After the disable is released, the output stays at that level until the next compare event. Two force strobes act like the duty or period compare event, but they never raise the event flag. A count-enable input stands in for a divide-by-one prescaler.

Top module: `pwm_buf_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the following values are loaded: counter = 1, active and staging duty = 1, active and staging period = 1, `pwm_out` = `polarity` and `flag` = 0.
- R2: The counter advances by one on each clock with `tick` = 1 and holds on each clock with `tick` = 0. Compare events occur only on clocks with `tick` = 1.
- R3: A period event occurs when the counter equals the active period on a ticking clock. After a period event the counter is 1, and `pwm_out` becomes the inverse of `polarity`.
- R4: A duty event occurs when the counter equals the active duty on a ticking clock, with no period event on that clock. After a duty event, `pwm_out` equals `polarity`.
- R5: When a duty event and a period event fall on the same clock, the period event decides the output. As a result, any duty value greater than or equal to the period value keeps `pwm_out` at the inverse of `polarity` for as long as the count runs.
- R6: `wr_a` writes `wr_data` to the staging duty value, and `wr_b` writes it to the staging period value. The active values take the staging values only on a period event. A write on the same clock as a period event takes effect at the following period event.
- R7: On a clock with `odis_en` = 1 and `odis_in` = 1, `pwm_out` becomes `polarity`. This overrides any event or force on that clock.
- R8: After the disable is released, `pwm_out` keeps the disabled level until the next duty event, period event or force.
- R9: `force_a` sets `pwm_out` to `polarity`. `force_b` sets `pwm_out` to the inverse of `polarity` and reloads the counter to 1, whether or not `tick` is high. When both strobes are high together, `force_b` decides the output.
- R10: Neither force strobe sets `flag`.
- R11: `flag` is set by every period event. It is cleared by `flag_clr` = 1. A period event on the same clock as a clear leaves `flag` set.
- R12: `odis_in` has no effect while `odis_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| polarity | input | 1 | Level driven by a duty event and by the disable |
| tick | input | 1 | Count enable (divide-by-one prescaler) |
| wr_a | input | 1 | Write `wr_data` to the staging duty value |
| wr_b | input | 1 | Write `wr_data` to the staging period value |
| wr_data | input | CNT_W | Write data for the staging values |
| force_a | input | 1 | Force a duty-style output change |
| force_b | input | 1 | Force a period-style output change and restart the counter |
| odis_en | input | 1 | Enable for the output-disable input |
| odis_in | input | 1 | Output-disable request |
| flag_clr | input | 1 | Write-one-to-clear for the event flag |
| pwm_out | output | 1 | PWM output flip-flop |
| flag | output | 1 | Period event flag |

## Verification
A wrong counter value or active compare value inside the channel stays hidden until the next compare event. At that point, `pwm_out` changes edge one clock early or late, and `flag` rises on the wrong clock. The error is therefore seen within one period of the programmed waveform. A staging value that loads early shows up as a changed edge inside the period in which it was written. An output flip-flop error appears at the port on the next clock. The bench compares both outputs against a behavioural model on every clock, so any such divergence is reported on the first clock where it reaches a port.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DUTY = 2'd1,
        ACT_PERIOD = 2'd2
    } out_act_t;

    typedef struct packed {
        logic hit_a;
        logic hit_b;
    } match_t;

    function automatic out_act_t resolve_act(input match_t m, input logic frc_a, input logic frc_b);
        if (m.hit_b || frc_b) return ACT_PERIOD;
        if (m.hit_a || frc_a) return ACT_DUTY;
        return ACT_NONE;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ONE;
        end else if (restart) begin
            cnt <= ONE;
        end else if (tick) begin
            cnt <= cnt + ONE;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             force_b,
    output match_t           hits
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] duty_stage, per_stage, duty_act, per_act;

    always_comb begin
        hits.hit_a = tick && (cnt == duty_act);
        hits.hit_b = tick && (cnt == per_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_stage <= ONE;
            per_stage <= ONE;
            duty_act <= ONE;
            per_act <= ONE;
        end else begin
            if (wr_a) duty_stage <= wr_data;
            if (wr_b) per_stage <= wr_data;
            if (hits.hit_b) begin
                duty_act <= duty_stage;
                per_act <= per_stage;
            end
        end
    end

    p_shadow_r6: assert property (@(posedge clk) disable iff (rst)
        !hits.hit_b |=> ($stable(duty_act) && $stable(per_act)));

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (hits.hit_b || force_b) |=> (cnt == ONE));

endmodule

// File: rtl/pwm_outctl.sv
module pwm_outctl
    import pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   polarity,
    input  match_t hits,
    input  logic   force_a,
    input  logic   force_b,
    input  logic   odis_en,
    input  logic   odis_in,
    input  logic   flag_clr,
    output logic   pwm_out,
    output logic   flag
);
    out_act_t act;
    logic     dis;

    always_comb begin
        act = resolve_act(hits, force_a, force_b);
        dis = odis_en && odis_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= polarity;
            flag <= 1'b0;
        end else begin
            if (dis) begin
                pwm_out <= polarity;
            end else if (act == ACT_PERIOD) begin
                pwm_out <= ~polarity;
            end else if (act == ACT_DUTY) begin
                pwm_out <= polarity;
            end
            if (hits.hit_b) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end

    p_disable_r7: assert property (@(posedge clk) disable iff (rst)
        dis |=> (pwm_out == $past(polarity)));

    p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
        hits.hit_b |=> flag);

    p_force_noflag_r10: assert property (@(posedge clk) disable iff (rst)
        (!flag && !hits.hit_b) |=> !flag);

endmodule

// File: rtl/pwm_buf_channel.sv
module pwm_buf_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             polarity,
    input  logic             tick,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             force_a,
    input  logic             force_b,
    input  logic             odis_en,
    input  logic             odis_in,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic             flag
);
    logic [CNT_W-1:0] cnt;
    match_t           hits;
    logic             restart;

    always_comb restart = hits.hit_b || force_b;

    pwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick), .restart(restart), .cnt(cnt)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_compare (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
        .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .force_b(force_b), .hits(hits)
    );

    pwm_outctl u_outctl (
        .clk(clk), .rst(rst), .polarity(polarity), .hits(hits),
        .force_a(force_a), .force_b(force_b),
        .odis_en(odis_en), .odis_in(odis_in), .flag_clr(flag_clr),
        .pwm_out(pwm_out), .flag(flag)
    );

endmodule

// File: tb/pwm_buf_channel_bench.sv
module pwm_buf_channel_bench;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic polarity = 1'b0;
    logic tick = 1'b0;
    logic wr_a = 1'b0;
    logic wr_b = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic force_a = 1'b0;
    logic force_b = 1'b0;
    logic odis_en = 1'b0;
    logic odis_in = 1'b0;
    logic flag_clr = 1'b0;
    logic pwm_out, flag;

    always #5 clk = ~clk;

    pwm_buf_channel #(.CNT_W(W)) u_pwm_buf_channel (
        .clk(clk), .rst(rst), .polarity(polarity), .tick(tick),
        .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .force_a(force_a), .force_b(force_b),
        .odis_en(odis_en), .odis_in(odis_in), .flag_clr(flag_clr),
        .pwm_out(pwm_out), .flag(flag)
    );

    // behavioural reference model
    longint m_cnt, m_a1, m_a2, m_b1, m_b2;
    bit m_out, m_flag;
    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        bit ha, hb;
        if (rst) begin
            m_cnt = 1; m_a1 = 1; m_a2 = 1; m_b1 = 1; m_b2 = 1;
            m_out = polarity; m_flag = 0;
        end else begin
            ha = tick && (m_cnt == m_a1);
            hb = tick && (m_cnt == m_b1);
            if (odis_en && odis_in) m_out = polarity;
            else if (hb || force_b) m_out = !polarity;
            else if (ha || force_a) m_out = polarity;
            if (hb) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (hb || force_b) m_cnt = 1;
            else if (tick) m_cnt = (m_cnt + 1) % (64'd1 << W);
            if (hb) begin m_a1 = m_a2; m_b1 = m_b2; end
            if (wr_a) m_a2 = longint'(wr_data);
            if (wr_b) m_b2 = longint'(wr_data);
        end
    end

    task automatic check(input bit act, input bit exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // one clock: compare at falling edge, inputs then change for next edge
    task automatic cyc();
        @(negedge clk);
        check(pwm_out, m_out, "pwm_out");
        check(flag, m_flag, "flag");
        wr_a = 0; wr_b = 0; force_a = 0; force_b = 0; flag_clr = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic load(input int a, input int b);
        wr_a = 1; wr_b = 0; wr_data = W'(a);
        @(negedge clk); check(pwm_out, m_out, "pwm_out"); check(flag, m_flag, "flag");
        wr_a = 0; wr_b = 1; wr_data = W'(b);
        cyc();
    endtask

    initial begin
        tick = 0;
        run(3);
        cur_req = "R1";
        check(pwm_out, 1'b0, "reset pwm_out");
        check(flag, 1'b0, "reset flag");
        rst = 0;
        cyc();
        cur_req = "R6";
        load(3, 6);
        tick = 1;
        run(3);
        cur_req = "R3";
        run(20);
        cur_req = "R2";
        for (int i = 0; i < 30; i++) begin tick = (i % 3) != 0; cyc(); end
        tick = 1;
        cur_req = "R6";
        run(2);
        load(2, 4);
        run(14);
        load(5, 9);
        run(20);
        cur_req = "R4";
        load(1, 7);
        run(20);
        cur_req = "R5";
        load(4, 4);
        run(20);
        load(9, 5);
        run(20);
        cur_req = "R11";
        load(3, 8);
        for (int i = 0; i < 40; i++) begin flag_clr = (i % 4) == 1; cyc(); end
        for (int i = 0; i < 24; i++) begin flag_clr = 1; cyc(); end
        cur_req = "R7";
        odis_en = 1;
        for (int i = 0; i < 48; i++) begin odis_in = (i % 11) < 3; cyc(); end
        odis_in = 0;
        cur_req = "R8";
        run(20);
        cur_req = "R12";
        odis_en = 0;
        for (int i = 0; i < 30; i++) begin odis_in = (i % 5) < 2; cyc(); end
        odis_in = 0;
        cur_req = "R10";
        flag_clr = 1; cyc();
        tick = 0;
        force_b = 1; cyc();
        run(2);
        force_a = 1; cyc();
        cur_req = "R9";
        tick = 1;
        for (int i = 0; i < 40; i++) begin
            force_a = (i % 7) == 2;
            force_b = (i % 9) == 4;
            cyc();
        end
        force_a = 1; force_b = 1; cyc();
        run(10);
        cur_req = "R1";
        polarity = 1; rst = 1; tick = 0;
        run(2);
        check(pwm_out, 1'b1, "reset pwm_out pol1");
        check(flag, 1'b0, "reset flag pol1");
        rst = 0;
        cur_req = "R4";
        load(2, 5);
        tick = 1;
        run(30);
        cur_req = "R7";
        odis_en = 1;
        for (int i = 0; i < 20; i++) begin odis_in = (i % 8) < 2; cyc(); end
        odis_in = 0;
        run(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule